// File: doc/BRIEF.md
# Multi-Master Bus Arbiter with Parked Idle Master

This block chooses which of several bus masters owns a shared pipelined system bus. Each real master raises a request line, and the arbiter answers with a one-hot grant vector. The granted master's address, transfer type, direction and size go to the slaves through an AND-OR multiplexer. Write data belongs to the data phase, which comes one completed transfer after the address phase. Write data is therefore steered by a second select. That select is a copy of the address-phase owner, taken on each cycle where the slave reports the transfer done.

Slot 0 is a built-in dummy master. It owns the bus whenever no real master (slots 1 to N-1) is asking. While it owns the bus it presents an IDLE transfer with a zero address and zero controls, so the bus never floats and never carries a stray transfer. The grant can change only on a clock edge where the bus ready input is high, so an address phase that a slave is stretching is never torn away from its master. Among the real masters, the lowest index always wins.

Top module: `mbus_arbiter`

## Requirements
- R1: While reset is low at a clock edge, the grant becomes slot 0 only (one-hot value 1), whatever the requests are. The bus then shows transfer type IDLE (2'b00) and zero write data.
- R2: The grant vector has exactly one bit set at every clock edge outside reset.
- R3: On an edge where ready is high, the grant moves to the lowest-indexed slot among 1..N-1 whose request is high.
- R4: On an edge where ready is low, the grant keeps its value, even when requests change.
- R5: On an edge where ready is high and no request in slots 1..N-1 is high, slot 0 is granted. While slot 0 is granted, the bus shows IDLE (2'b00) with zero address, write flag and size.
- R6: Request bit 0 and all bus inputs of slot 0 have no effect on the grant or on any output.
- R7: Address, transfer type, write flag and size outputs equal those of the currently granted slot, within the same cycle.
- R8: Write data out comes from the slot that held the grant before the most recent ready-high edge. It is zero when that slot was 0, and it holds its source across edges where ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N | Request per slot; bit 0 is ignored |
| ready_i | input | 1 | Bus ready; high completes the current transfer |
| m_addr_i | input | N*ADDR_W | Address per slot, slot i at bits [i*ADDR_W +: ADDR_W] |
| m_trans_i | input | 2*N | Transfer type per slot |
| m_write_i | input | N | Write flag per slot |
| m_size_i | input | 3*N | Transfer size per slot |
| m_wdata_i | input | N*DATA_W | Write data per slot |
| grant_o | output | N | One-hot grant |
| addr_o | output | ADDR_W | Shared bus address |
| trans_o | output | 2 | Shared bus transfer type |
| write_o | output | 1 | Shared bus write flag |
| size_o | output | 3 | Shared bus transfer size |
| wdata_o | output | DATA_W | Shared bus write data |

## Verification
The bench gives slot 0 nonzero inputs and keeps its request high. A design that routed the dummy slot's inputs through the multiplexer, or that counted its request, would show them on the bus. A lower-priority master already holds the grant while ready is low and a higher one starts requesting. An arbiter that switched without waiting for ready would move the grant in the middle of a stretched transfer. A sequence of back-to-back grant changes, with a stall in between, checks that write data trails the address owner by exactly one completed transfer. A design that switched both multiplexers together, or that advanced the data select during a stall, would put the wrong master's data on the bus.

// File: rtl/mbus_arb_pkg.sv
// Package: shared constants for the multi-master bus arbiter.
// Assumes a two-bit transfer-type encoding with IDLE = 2'b00.
package mbus_arb_pkg;
    localparam int TRANS_W = 2;
    localparam int SIZE_W  = 3;
    localparam logic [TRANS_W-1:0] TRANS_IDLE   = 2'b00;
    localparam logic [TRANS_W-1:0] TRANS_NONSEQ = 2'b10;
endpackage

// File: rtl/mbus_arb_pick.sv
// Fixed-priority picker: among slots 1..N-1 the lowest requesting index
// wins; slot 0 (dummy master) is picked only when no real slot requests.
// Assumes N >= 2. Output is always one-hot.
module mbus_arb_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pick_o
);
    // Walk slots upward; first requester found takes the pick.
    always_comb begin
        logic found;
        found  = 1'b0;
        pick_o = '0;
        for (int i = 1; i < N; i++) begin
            if (req_i[i] && !found) begin
                pick_o[i] = 1'b1;
                found     = 1'b1;
            end
        end
        pick_o[0] = !found;
    end
endmodule

// File: rtl/mbus_arb_state.sv
// Grant state: address-phase grant and data-phase owner, both one-hot.
// Both advance only on edges where ready is high; the data owner takes
// the address grant it replaces. Synchronous active-low reset to slot 0.
module mbus_arb_state #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ready_i,
    input  logic [N-1:0] pick_i,
    output logic [N-1:0] agrant_o,
    output logic [N-1:0] dgrant_o
);
    localparam logic [N-1:0] PARK = {{(N-1){1'b0}}, 1'b1};

    // Advance both phase owners when the current transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            agrant_o <= PARK;
            dgrant_o <= PARK;
        end else if (ready_i) begin
            agrant_o <= pick_i;
            dgrant_o <= agrant_o;
        end
    end
endmodule

// File: rtl/mbus_arb_mux.sv
// One-hot AND-OR multiplexer over N lanes of W bits each.
// Assumes sel_i is one-hot or zero; zero select gives zero output.
module mbus_arb_mux #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]   sel_i,
    input  logic [N*W-1:0] din_i,
    output logic [W-1:0]   dout_o
);
    // OR together every lane whose select bit is set.
    always_comb begin
        dout_o = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_i[i]) dout_o = dout_o | din_i[i*W +: W];
        end
    end
endmodule

// File: rtl/mbus_arbiter.sv
// Top level: multi-master bus arbiter with slot 0 as a parked dummy
// master driving IDLE. Address/control are steered by the registered
// grant; write data by the grant delayed one completed transfer.
// Assumes N >= 2; slot 0 inputs and req_i[0] are never used.
module mbus_arbiter
    import mbus_arb_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_i,
    input  logic                ready_i,
    input  logic [N*ADDR_W-1:0] m_addr_i,
    input  logic [2*N-1:0]      m_trans_i,
    input  logic [N-1:0]        m_write_i,
    input  logic [3*N-1:0]      m_size_i,
    input  logic [N*DATA_W-1:0] m_wdata_i,
    output logic [N-1:0]        grant_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [1:0]          trans_o,
    output logic                write_o,
    output logic [2:0]          size_o,
    output logic [DATA_W-1:0]   wdata_o
);
    localparam int CTL_W = ADDR_W + TRANS_W + 1 + SIZE_W;

    logic [N-1:0]        req_real;
    logic [N-1:0]        pick;
    logic [N-1:0]        dgrant;
    logic [N*CTL_W-1:0]  ctl_lanes;
    logic [N*DATA_W-1:0] wd_lanes;
    logic [CTL_W-1:0]    ctl_bus;
    logic                unused_slot0;

    // Slot 0 inputs are deliberately dropped.
    assign unused_slot0 = ^{req_i[0], m_addr_i[ADDR_W-1:0], m_trans_i[1:0],
                            m_write_i[0], m_size_i[2:0], m_wdata_i[DATA_W-1:0]};
    assign req_real = {req_i[N-1:1], 1'b0};

    // Build mux lanes: slot 0 is a constant IDLE master, others pass through.
    for (genvar i = 0; i < N; i++) begin : g_lane
        if (i == 0) begin : g_dummy
            assign ctl_lanes[0 +: CTL_W]  = {{ADDR_W{1'b0}}, TRANS_IDLE, 1'b0, {SIZE_W{1'b0}}};
            assign wd_lanes[0 +: DATA_W]  = '0;
        end else begin : g_real
            assign ctl_lanes[i*CTL_W +: CTL_W] = {m_addr_i[i*ADDR_W +: ADDR_W],
                                                  m_trans_i[i*2 +: 2],
                                                  m_write_i[i],
                                                  m_size_i[i*3 +: 3]};
            assign wd_lanes[i*DATA_W +: DATA_W] = m_wdata_i[i*DATA_W +: DATA_W];
        end
    end

    mbus_arb_pick #(.N(N)) u_pick (
        .req_i  (req_real),
        .pick_o (pick)
    );

    mbus_arb_state #(.N(N)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready_i  (ready_i),
        .pick_i   (pick),
        .agrant_o (grant_o),
        .dgrant_o (dgrant)
    );

    mbus_arb_mux #(.N(N), .W(CTL_W)) u_ctl_mux (
        .sel_i  (grant_o),
        .din_i  (ctl_lanes),
        .dout_o (ctl_bus)
    );

    mbus_arb_mux #(.N(N), .W(DATA_W)) u_wd_mux (
        .sel_i  (dgrant),
        .din_i  (wd_lanes),
        .dout_o (wdata_o)
    );

    // Unpack the steered control lane onto the bus outputs.
    assign {addr_o, trans_o, write_o, size_o} = ctl_bus;
endmodule

// File: rtl/mbus_arbiter_chk.sv
// Checker for mbus_arbiter: temporal properties on grant and bus outputs.
// Assumes N >= 2. Attached to every mbus_arbiter instance by bind.
module mbus_arbiter_chk #(
    parameter int N      = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N-1:0]        req_i,
    input logic                ready_i,
    input logic [N*ADDR_W-1:0] m_addr_i,
    input logic [N-1:0]        grant_o,
    input logic [ADDR_W-1:0]   addr_o,
    input logic [1:0]          trans_o,
    input logic [DATA_W-1:0]   wdata_o
);
    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1);

    // R4
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(grant_o));

    // R3
    top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && req_i[1]) |=> grant_o[1]);

    // R5
    park_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && (req_i[N-1:1] == '0)) |=> grant_o[0]);

    // R5
    park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[0] |-> (trans_o == 2'b00 && addr_o == '0));

    // R7
    addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[1] |-> (addr_o == m_addr_i[ADDR_W +: ADDR_W]));

    // R8
    wdata_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && grant_o[0]) |=> (wdata_o == '0));
endmodule

bind mbus_arbiter mbus_arbiter_chk #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .ready_i  (ready_i),
    .m_addr_i (m_addr_i),
    .grant_o  (grant_o),
    .addr_o   (addr_o),
    .trans_o  (trans_o),
    .wdata_o  (wdata_o)
);

// File: tb/mbus_arbiter_test.sv
// Directed bench for mbus_arbiter: one task per scenario, each self-checking.
module mbus_arbiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 4;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WDOG   = 5000;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [N-1:0]        req_i;
    logic                ready_i;
    logic [N*ADDR_W-1:0] m_addr_i;
    logic [2*N-1:0]      m_trans_i;
    logic [N-1:0]        m_write_i;
    logic [3*N-1:0]      m_size_i;
    logic [N*DATA_W-1:0] m_wdata_i;
    logic [N-1:0]        grant_o;
    logic [ADDR_W-1:0]   addr_o;
    logic [1:0]          trans_o;
    logic                write_o;
    logic [2:0]          size_o;
    logic [DATA_W-1:0]   wdata_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_arbiter #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

    function automatic logic [ADDR_W-1:0] a_of(int i);
        return 32'h1000_0000 * i + 32'h40;
    endfunction
    function automatic logic [DATA_W-1:0] d_of(int i);
        return 32'hD000_0000 + i;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one edge and land a quarter period after it.
    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk_grant(input logic [N-1:0] exp, input string tag);
        chk(grant_o == exp, tag, 64'(grant_o), 64'(exp));
        chk($countones(grant_o) == 1, "R2 grant one-hot", 64'(grant_o), 64'(exp));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_i = '1; ready_i = 1'b1;
        step(); step();
        chk_grant(4'b0001, "R1 grant in reset");
        chk(trans_o == 2'b00, "R1 trans IDLE in reset", 64'(trans_o), 64'(0));
        chk(wdata_o == '0, "R1 wdata zero in reset", 64'(wdata_o), 64'(0));
        rst_n = 1'b1; req_i = '0;
        step();
    endtask

    task automatic t_priority();
        ready_i = 1'b1;
        req_i = 4'b1111; step();
        chk_grant(4'b0010, "R3 slot1 wins all");
        chk(addr_o == a_of(1), "R7 addr slot1", 64'(addr_o), 64'(a_of(1)));
        chk(trans_o == 2'b10 && write_o && size_o == 3'b010, "R7 ctl slot1",
            64'({trans_o, write_o, size_o}), 64'({2'b10, 1'b1, 3'b010}));
        req_i = 4'b1100; step();
        chk_grant(4'b0100, "R3 slot2 over slot3");
        chk(addr_o == a_of(2), "R7 addr slot2", 64'(addr_o), 64'(a_of(2)));
        req_i = 4'b1000; step();
        chk_grant(4'b1000, "R3 slot3 alone");
        chk(addr_o == a_of(3), "R7 addr slot3", 64'(addr_o), 64'(a_of(3)));
    endtask

    task automatic t_hold();
        ready_i = 1'b0; req_i = 4'b0010;
        for (int k = 0; k < 3; k++) begin
            step();
            chk_grant(4'b1000, "R4 hold while ready low");
        end
        req_i = 4'b0000; step();
        chk_grant(4'b1000, "R4 hold after request drop");
        ready_i = 1'b1; req_i = 4'b0010; step();
        chk_grant(4'b0010, "R3 switch on ready high");
    endtask

    task automatic t_park();
        ready_i = 1'b1; req_i = 4'b0001; step();
        chk_grant(4'b0001, "R6 req0 ignored, R5 park");
        chk(trans_o == 2'b00, "R5 IDLE when parked", 64'(trans_o), 64'(0));
        chk(addr_o == '0 && !write_o && size_o == '0, "R6 slot0 inputs ignored",
            64'({addr_o, write_o, size_o}), 64'(0));
        step();
        chk(wdata_o == '0, "R6 slot0 wdata ignored", 64'(wdata_o), 64'(0));
    endtask

    task automatic t_wdata();
        ready_i = 1'b1; req_i = 4'b0010; step();
        chk_grant(4'b0010, "R3 slot1 from park");
        chk(wdata_o == '0, "R8 wdata still dummy", 64'(wdata_o), 64'(0));
        req_i = 4'b0100; step();
        chk(wdata_o == d_of(1), "R8 wdata slot1 lags", 64'(wdata_o), 64'(d_of(1)));
        ready_i = 1'b0; req_i = 4'b1000; step(); step();
        chk(wdata_o == d_of(1), "R8 wdata held on stall", 64'(wdata_o), 64'(d_of(1)));
        chk_grant(4'b0100, "R4 grant held on stall");
        ready_i = 1'b1; step();
        chk(wdata_o == d_of(2), "R8 wdata slot2", 64'(wdata_o), 64'(d_of(2)));
        req_i = 4'b0000; step();
        chk(wdata_o == d_of(3), "R8 wdata slot3", 64'(wdata_o), 64'(d_of(3)));
        chk_grant(4'b0001, "R5 park after last");
        step();
        chk(wdata_o == '0, "R8 wdata zero after park", 64'(wdata_o), 64'(0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; req_i = '0; ready_i = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_addr_i[i*ADDR_W +: ADDR_W]  = (i == 0) ? 32'hFFFF_FFFC : a_of(i);
            m_trans_i[i*2 +: 2]           = (i == 0) ? 2'b11 : 2'b10;
            m_write_i[i]                  = 1'b1;
            m_size_i[i*3 +: 3]            = (i == 0) ? 3'b111 : 3'b010;
            m_wdata_i[i*DATA_W +: DATA_W] = (i == 0) ? 32'hBAD0_0BAD : d_of(i);
        end
        #(CLK_PERIOD/4);
        t_reset();
        t_priority();
        t_hold();
        t_park();
        t_wdata();
        finish_run();
    end
endmodule